// File: doc/BRIEF.md
# Double Comma Symbol Aligner

This block finds the 10-bit character boundaries in an 8B/10B line stream. The stream arrives as unaligned 10-bit parallel words, one per clock. The block joins the previous word and the current word into a 20-bit window. In one cycle it compares every one of the ten possible bit phases against both running-disparity forms of the K28.5 comma. A two-bit mode input sets which comma forms may fix the boundary. Once a boundary is accepted, the block sends out 10-bit words that match the transmitted characters bit for bit.

The strict paired mode guards against false realignment on noisy or fast links. It accepts a boundary only when a comma of one disparity is followed at once, with no gap bits, by a comma of the opposite disparity. After lock, the block moves the boundary only when a new accepted comma appears at a different phase, and it flags each such move with a one-cycle pulse. A strobe marks each cycle in which the output word is an accepted comma.

Top module: `comma_aligner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `locked`, `realign` and `comma_seen` are low and `out_word` is zero.
- R2: Bit 9 of `in_word` is the first bit received on the line. When the characters reach the block shifted by any phase p from 0 to 9, the block locks. After lock, each `out_word` equals the transmitted character that began two input words earlier, bit for bit.
- R3: Mode 2'b00 (either) accepts K28.5 in either form as a boundary: 0011111010 (negative disparity) or 1100000101 (positive disparity). Both are written with bit 9 first. A stream of data characters with no comma leaves `locked` low.
- R4: Mode 2'b01 (plus only) accepts only 1100000101. A 0011111010 comma leaves `locked` low.
- R5: Mode 2'b10 (minus only) accepts only 0011111010. A 1100000101 comma leaves `locked` low.
- R6: Mode 2'b11 (paired) accepts a boundary only when a comma at a phase is followed at once, at the same phase, by the comma of opposite disparity. Two equal commas, or two commas with a data character between them, leave `locked` low. The output word at acceptance is the second comma.
- R7: The first acceptance after unlock sets `locked` without a `realign` pulse. While locked, an accepted comma at a different phase moves the boundary and raises `realign` for exactly one cycle. `locked` stays high.
- R8: While locked, an accepted comma at the current phase raises `comma_seen` without `realign`.
- R9: A change of `mode` clears `locked` one cycle later.
- R10: `comma_seen` is high exactly in the cycles in which `out_word` holds an accepted comma. It is never high while unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 10 | Unaligned line word, bit 9 received first |
| mode | input | 2 | Comma acceptance mode (either, plus, minus, paired) |
| out_word | output | 10 | Character at the locked boundary |
| locked | output | 1 | A boundary has been accepted |
| realign | output | 1 | One-cycle pulse when a locked boundary moves |
| comma_seen | output | 1 | Output word is an accepted comma |

## Verification
The bench builds the block with its only configuration: a 10-bit symbol and a 20-bit window, taken from package constants. This puts all ten phases within reach of a single-cycle search. The bench runs the stream at phases 0, 3, 5, 7 and 9. That covers both edges of the window and a boundary move from phase 3 to phase 7 while locked. Each mode meets both disparity forms, and paired mode also meets equal pairs and gapped pairs.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

    localparam int SYM_W = 10;
    localparam int WIN_W = 2 * SYM_W;
    localparam int OFF_W = $clog2(SYM_W);

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [OFF_W-1:0] off_t;
    typedef logic [WIN_W-1:0] win_t;

    // K28.5 forms, first line bit in bit 9
    localparam sym_t K285_RDN = 10'b0011111010;
    localparam sym_t K285_RDP = 10'b1100000101;

    typedef enum logic [1:0] {
        MODE_EITHER = 2'b00,
        MODE_PLUS   = 2'b01,
        MODE_MINUS  = 2'b10,
        MODE_PAIRED = 2'b11
    } match_mode_e;

    // bit k of each vector refers to window phase k
    typedef struct packed {
        sym_t pos;
        sym_t neg;
    } hit_set_t;

    function automatic sym_t accept_hits(match_mode_e m, hit_set_t cur, hit_set_t prev);
        sym_t r;
        unique case (m)
            MODE_PLUS:   r = cur.pos;
            MODE_MINUS:  r = cur.neg;
            MODE_PAIRED: r = (prev.neg & cur.pos) | (prev.pos & cur.neg);
            default:     r = cur.pos | cur.neg;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ca_window_tap.sv
module ca_window_tap
    import comma_align_pkg::*;
(
    input  win_t                  window,
    output logic [SYM_W-1:0][SYM_W-1:0] taps
);
    // tap k is the 10-bit character starting k bits into the window
    for (genvar k = 0; k < SYM_W; k++) begin : g_tap
        assign taps[k] = window[WIN_W-1-k -: SYM_W];
    end
endmodule

// File: rtl/ca_comma_match.sv
module ca_comma_match
    import comma_align_pkg::*;
(
    input  logic [SYM_W-1:0][SYM_W-1:0] taps,
    output hit_set_t                    hits
);
    for (genvar k = 0; k < SYM_W; k++) begin : g_cmp
        assign hits.pos[k] = (taps[k] == K285_RDP);
        assign hits.neg[k] = (taps[k] == K285_RDN);
    end
endmodule

// File: rtl/ca_policy_select.sv
module ca_policy_select
    import comma_align_pkg::*;
(
    input  match_mode_e mode,
    input  hit_set_t    cur_hits,
    input  hit_set_t    prev_hits,
    output logic        any_hit,
    output off_t        sel_off
);
    sym_t valid;

    assign valid   = accept_hits(mode, cur_hits, prev_hits);
    assign any_hit = |valid;

    // lowest phase has priority: scan downward so it is written last
    always_comb begin
        sel_off = '0;
        for (int k = SYM_W - 1; k >= 0; k--) begin
            if (valid[k]) sel_off = OFF_W'(k);
        end
    end
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
    import comma_align_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [9:0] in_word,
    input  logic [1:0] mode,
    output logic [9:0] out_word,
    output logic       locked,
    output logic       realign,
    output logic       comma_seen
);
    sym_t        prev_word;
    hit_set_t    cur_hits;
    hit_set_t    prev_hits;
    match_mode_e mode_now;
    match_mode_e mode_q;
    off_t        off_q, off_d, sel_off;
    logic        lock_q, lock_d;
    logic        realign_q, realign_d;
    logic        comma_q, comma_d;
    logic        any_hit;
    logic        mode_chg;
    sym_t        out_q, aligned;
    logic [SYM_W-1:0][SYM_W-1:0] taps;

    assign mode_now = match_mode_e'(mode);
    assign mode_chg = (mode_now != mode_q);

    ca_window_tap u_tap (
        .window ({prev_word, in_word}),
        .taps   (taps)
    );

    ca_comma_match u_match (
        .taps (taps),
        .hits (cur_hits)
    );

    ca_policy_select u_sel (
        .mode      (mode_q),
        .cur_hits  (cur_hits),
        .prev_hits (prev_hits),
        .any_hit   (any_hit),
        .sel_off   (sel_off)
    );

    always_comb begin
        off_d     = off_q;
        lock_d    = lock_q;
        realign_d = 1'b0;
        comma_d   = 1'b0;
        if (mode_chg) begin
            lock_d = 1'b0;
        end else if (any_hit) begin
            comma_d = 1'b1;
            if (!lock_q) begin
                off_d  = sel_off;
                lock_d = 1'b1;
            end else if (sel_off != off_q) begin
                off_d     = sel_off;
                realign_d = 1'b1;
            end
        end
    end

    always_comb begin
        aligned = '0;
        for (int k = 0; k < SYM_W; k++) begin
            if (off_d == OFF_W'(k)) aligned = taps[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_word <= '0;
            prev_hits <= '0;
            mode_q    <= mode_now;
            off_q     <= '0;
            lock_q    <= 1'b0;
            realign_q <= 1'b0;
            comma_q   <= 1'b0;
            out_q     <= '0;
        end else begin
            prev_word <= in_word;
            prev_hits <= cur_hits;
            mode_q    <= mode_now;
            off_q     <= off_d;
            lock_q    <= lock_d;
            realign_q <= realign_d;
            comma_q   <= comma_d;
            out_q     <= aligned;
        end
    end

    assign out_word   = out_q;
    assign locked     = lock_q;
    assign realign    = realign_q;
    assign comma_seen = comma_q;

endmodule

// File: rtl/comma_aligner_checker.sv
module comma_aligner_checker
    import comma_align_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic [9:0] out_word,
    input logic       locked,
    input logic       realign,
    input logic       comma_seen
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!locked && !realign && !comma_seen && out_word == '0));

    a_r7_realign_while_locked: assert property (@(posedge clk) disable iff (rst)
        realign |-> (locked && $past(locked)));

    a_r9_mode_change_unlocks: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |=> !locked);

    a_r10_comma_needs_lock: assert property (@(posedge clk) disable iff (rst)
        comma_seen |-> locked);

    a_r10_comma_is_k285: assert property (@(posedge clk) disable iff (rst)
        comma_seen |-> (out_word == K285_RDP || out_word == K285_RDN));

    a_r4_plus_only_form: assert property (@(posedge clk) disable iff (rst)
        (comma_seen && $past(mode) == MODE_PLUS) |-> out_word == K285_RDP);

    a_r5_minus_only_form: assert property (@(posedge clk) disable iff (rst)
        (comma_seen && $past(mode) == MODE_MINUS) |-> out_word == K285_RDN);
endmodule

bind comma_aligner comma_aligner_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .out_word   (out_word),
    .locked     (locked),
    .realign    (realign),
    .comma_seen (comma_seen)
);

// File: tb/test_comma_aligner.sv
`timescale 1ns/1ps
module test_comma_aligner;
    localparam logic [9:0] KN = 10'b0011111010;
    localparam logic [9:0] KP = 10'b1100000101;
    localparam logic [9:0] D1 = 10'b1010101010;
    localparam logic [9:0] D2 = 10'b0110011001;
    localparam logic [9:0] D3 = 10'b1101001011;
    localparam logic [9:0] D4 = 10'b0100110101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] in_word = '0;
    logic [1:0] mode = 2'b00;
    logic [9:0] out_word;
    logic       locked, realign, comma_seen;

    int         n_checks = 0;
    int         n_fail = 0;
    int         phase = 0;
    logic [9:0] last_sym = '0;
    logic [9:0] exp_out = '0;
    bit         finished = 0;

    always #10 clk = ~clk;

    comma_aligner i_comma_aligner (
        .clk(clk), .rst(rst), .in_word(in_word), .mode(mode),
        .out_word(out_word), .locked(locked), .realign(realign),
        .comma_seen(comma_seen)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // line stream shifted by 'phase' bits; exp_out = character two words back
    task automatic send(input logic [9:0] sym);
        logic [19:0] cat;
        cat      = {last_sym, sym};
        in_word  = cat[9+phase -: 10];
        exp_out  = last_sym;
        last_sym = sym;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 locked", 16'(locked), 16'd0);
        check("R1 realign", 16'(realign), 16'd0);
        check("R1 comma_seen", 16'(comma_seen), 16'd0);
        check("R1 out_word", 16'(out_word), 16'd0);
        rst = 1'b0;
        send(D1);
        check("R1 locked after release", 16'(locked), 16'd0);
    endtask

    task automatic t_either;
        mode  = 2'b00;
        phase = 3;
        send(D1); send(D2); send(D3); send(D4);
        check("R3 no comma no lock", 16'(locked), 16'd0);
        send(KN); send(D1);
        check("R3 lock on minus form", 16'(locked), 16'd1);
        check("R2 comma word exact", 16'(out_word), 16'(KN));
        check("R7 first lock no realign", 16'(realign), 16'd0);
        check("R10 strobe on comma", 16'(comma_seen), 16'd1);
        send(D2);
        check("R2 data exact phase3 a", 16'(out_word), 16'(exp_out));
        check("R10 strobe low on data", 16'(comma_seen), 16'd0);
        send(D3);
        check("R2 data exact phase3 b", 16'(out_word), 16'(D2));
        send(KP); send(D4);
        check("R3 plus form accepted", 16'(out_word), 16'(KP));
        check("R8 same phase strobe", 16'(comma_seen), 16'd1);
        check("R8 same phase no realign", 16'(realign), 16'd0);
    endtask

    task automatic t_realign;
        phase = 7;
        send(D1); send(D2); send(D3);
        check("R7 lock held across slip", 16'(locked), 16'd1);
        send(KP); send(D4);
        check("R7 realign pulse", 16'(realign), 16'd1);
        check("R7 lock stays", 16'(locked), 16'd1);
        check("R2 comma at new phase", 16'(out_word), 16'(KP));
        send(D1);
        check("R7 pulse one cycle", 16'(realign), 16'd0);
        check("R2 data exact phase7", 16'(out_word), 16'(D4));
    endtask

    task automatic t_plus;
        mode  = 2'b01;
        phase = 5;
        send(D1);
        check("R9 unlock on mode change", 16'(locked), 16'd0);
        send(D2); send(KN); send(D3);
        check("R4 minus form ignored", 16'(locked), 16'd0);
        check("R4 no strobe on ignored", 16'(comma_seen), 16'd0);
        send(KP); send(D4);
        check("R4 plus form locks", 16'(locked), 16'd1);
        check("R4 out is plus form", 16'(out_word), 16'(KP));
    endtask

    task automatic t_minus;
        mode  = 2'b10;
        phase = 0;
        send(D1);
        check("R9 unlock entering minus", 16'(locked), 16'd0);
        send(D2); send(KP); send(D3);
        check("R5 plus form ignored", 16'(locked), 16'd0);
        send(KN); send(D4);
        check("R5 minus form locks", 16'(locked), 16'd1);
        check("R5 out is minus form", 16'(out_word), 16'(KN));
        send(D2);
        check("R2 data exact phase0", 16'(out_word), 16'(D4));
    endtask

    task automatic t_paired;
        mode  = 2'b11;
        phase = 9;
        send(D1);
        check("R9 unlock entering paired", 16'(locked), 16'd0);
        send(KN); send(KN); send(D2);
        check("R6 equal pair ignored", 16'(locked), 16'd0);
        send(KN); send(D3); send(KP); send(D4);
        check("R6 gapped pair ignored", 16'(locked), 16'd0);
        send(D1); send(KN); send(KP); send(D2);
        check("R6 opposite pair locks", 16'(locked), 16'd1);
        check("R6 out is second comma", 16'(out_word), 16'(KP));
        check("R10 strobe on paired", 16'(comma_seen), 16'd1);
        send(KN);
        check("R2 data exact phase9", 16'(out_word), 16'(D2));
        check("R10 strobe low on data", 16'(comma_seen), 16'd0);
        send(KP); send(D3);
        check("R8 paired same phase strobe", 16'(comma_seen), 16'd1);
        check("R8 paired no realign", 16'(realign), 16'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        @(posedge clk);
        #2;
        t_reset();
        t_either();
        t_realign();
        t_plus();
        t_minus();
        t_paired();
        finish_run();
    end
endmodule